// File: doc/BRIEF.md
# Parallel Display Bus Strobe Timer

This block times one access on an 8080-style parallel display bus. A one-clock start request names the access type (command write, data write or read). The block then steps a tick counter from 0 and drives the chip-select, write-strobe, read-strobe and command/data select pins. Each edge sits at a tick count that software programs. One tick lasts one or two core clocks, set by a divider input.

Two packed timing words set the strobe edges, the cycle lengths and a chip-select recovery gap. A separate input gives the tick at which read data is sampled. On a read, the sampled bus value appears on an output with a one-clock valid pulse. A one-clock done pulse closes every access. A start that arrives while busy is high is dropped. The timing words and the access type are latched at the accepted start, so changing the inputs mid-cycle has no effect on the cycle in flight.

Top module: `disp_strobe_timer`

## Requirements
- R1: After reset, busy_o, done_o and rd_valid_o are low, and every strobe pin sits at its inactive level. Command/data select idles at the command level.
- R2: Chip select is active while the tick count t satisfies cs_on <= t < E, where E = max(cs_off, we_off, re_off). A cs_off programmed below either strobe's off tick is therefore raised to it.
- R3: On a write (kind 0 = command, kind 1 = data), the write strobe is active for we_on <= t < we_off, and the read strobe stays inactive.
- R4: On a read (kind 2), the read strobe is active for re_on <= t < re_off, and the write strobe stays inactive.
- R5: The command/data select takes its command level for kind 0 and its data level for kinds 1 and 2. It switches at the accepted start and holds its level until the next accepted start.
- R6: An access lasts N = max(C, E) + G ticks, where C is we_cyc on writes and re_cyc on reads, and G is the gap field. busy_o is high from the clock after the start through the last tick. done_o is high for exactly the next clock, with busy_o low.
- R7: clk_div_i = 1 gives one-clock ticks, and clk_div_i = 2 gives two-clock ticks.
- R8: A start with clk_div_i equal to 0 or 3, or with kind 3, is ignored: busy_o, done_o and the pins do not change.
- R9: A start while busy_o is high is ignored. The running access keeps its latched timing and type and ends with a single done pulse.
- R10: On a read, rd_data_o takes the value that rd_data_i had in the first clock of tick access_tick_i. rd_valid_o is high for one clock right after that clock. Writes never raise rd_valid_o.
- R11: Polarity bits are assigned as pol_i[0] to command/data select, [1] to read strobe, [2] to write strobe and [3] to chip select. A bit of 1 makes the pin active-high. A bit of 0 makes it active-low. The select pin's data level is 1 when its bit is 1.
- R12: The on/off word packs cs_on [3:0], cs_off [9:4], we_on [13:10], we_off [19:14], re_on [23:20] and re_off [29:24]. The cycle word packs we_cyc [5:0], re_cyc [11:6] and the chip-select gap [17:12].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, one clock |
| kind_i | input | 2 | Access type: 0 command write, 1 data write, 2 read |
| clk_div_i | input | 2 | Clocks per tick, 1 or 2 |
| onoff_tim_i | input | 30 | Packed strobe on/off ticks |
| cyc_tim_i | input | 18 | Packed cycle lengths and chip-select gap |
| access_tick_i | input | 6 | Read sampling tick |
| pol_i | input | 4 | Pin polarity bits |
| rd_data_i | input | DATA_W | Display data bus input |
| cs_o | output | 1 | Chip select pin |
| we_o | output | 1 | Write strobe pin |
| re_o | output | 1 | Read strobe pin |
| a0_o | output | 1 | Command/data select pin |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | Access finished, one clock |
| rd_data_o | output | DATA_W | Captured read data |
| rd_valid_o | output | 1 | Read data valid, one clock |

## Verification
Any state error shows up at the pins within one tick. A counter that is off by one moves a strobe edge by a whole tick, and a wrong divider phase stretches or shrinks every edge. Both appear as a mismatch in the per-clock pin comparison. A timing word that is not held stable would shift edges after a mid-cycle start attempt. A bad end-of-cycle test moves or duplicates done_o. A misplaced read capture returns a different bus sample, because the bus value changes on every clock.

// File: rtl/disp_strobe_pkg.sv
package disp_strobe_pkg;
  localparam int ON_W  = 4;
  localparam int OFF_W = 6;
  localparam int CNT_W = OFF_W + 1;
  localparam int NSTB  = 3;  // cs, we, re windows

  typedef enum logic [1:0] {
    ACC_CMD = 2'd0,
    ACC_DAT = 2'd1,
    ACC_RD  = 2'd2,
    ACC_BAD = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic [OFF_W-1:0] re_off;
    logic [ON_W-1:0]  re_on;
    logic [OFF_W-1:0] we_off;
    logic [ON_W-1:0]  we_on;
    logic [OFF_W-1:0] cs_off;
    logic [ON_W-1:0]  cs_on;
  } onoff_t;

  typedef struct packed {
    logic [OFF_W-1:0] cs_gap;
    logic [OFF_W-1:0] re_cyc;
    logic [OFF_W-1:0] we_cyc;
  } cyc_t;
endpackage

// File: rtl/dst_tick_div.sv
module dst_tick_div (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  input  logic div2_i,
  output logic tick_o,
  output logic ph_o
);
  logic ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ph_q <= 1'b0;
    else if (clear_i)           ph_q <= 1'b0;
    else if (run_i && div2_i)   ph_q <= ~ph_q;
  end

  assign tick_o = run_i && (!div2_i || ph_q);
  assign ph_o   = ph_q;

  // R7: with two-clock ticks, a tick is never followed by another tick
  a_r7_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && div2_i && tick_o) |=> !tick_o);
endmodule

// File: rtl/dst_window.sv
module dst_window #(
  parameter int CNT_W = 7,
  parameter int ON_W  = 4,
  parameter int OFF_W = 6
) (
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [ON_W-1:0]  on_i,
  input  logic [CNT_W-1:0] off_i,
  output logic             act_o
);
  assign act_o = en_i && (cnt_i >= CNT_W'(on_i)) && (cnt_i < off_i);
endmodule

// File: rtl/dst_seq.sv
module dst_seq
  import disp_strobe_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        kind_i,
  input  logic [1:0]        div_i,
  input  onoff_t            onoff_i,
  input  cyc_t              cyc_i,
  input  logic [OFF_W-1:0]  acc_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              tick_i,
  input  logic              ph_i,
  output logic              accept_o,
  output logic              run_o,
  output logic              div2_o,
  output logic [CNT_W-1:0]  cnt_o,
  output onoff_t            tim_o,
  output logic [CNT_W-1:0]  cs_end_o,
  output acc_kind_e         kind_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  logic              run_q, div2_q, done_q, rv_q;
  logic [CNT_W-1:0]  cnt_q;
  onoff_t            tim_q;
  cyc_t              cyc_q;
  logic [OFF_W-1:0]  acc_q;
  acc_kind_e         kind_q;
  logic [DATA_W-1:0] rd_q;

  logic             legal;
  logic [CNT_W-1:0] cs_end, cyc_sel, body, end_raw, last;
  logic             last_tick, capture;

  assign legal    = ((div_i == 2'd1) || (div_i == 2'd2)) && (kind_i != ACC_BAD);
  assign accept_o = !run_q && start_i && legal;

  always_comb begin
    cs_end = CNT_W'(tim_q.cs_off);
    if (CNT_W'(tim_q.we_off) > cs_end) cs_end = CNT_W'(tim_q.we_off);
    if (CNT_W'(tim_q.re_off) > cs_end) cs_end = CNT_W'(tim_q.re_off);
    cyc_sel = (kind_q == ACC_RD) ? CNT_W'(cyc_q.re_cyc) : CNT_W'(cyc_q.we_cyc);
    body    = (cyc_sel > cs_end) ? cyc_sel : cs_end;
    end_raw = body + CNT_W'(cyc_q.cs_gap);
    last    = (end_raw == '0) ? '0 : end_raw - 1'b1;
  end

  assign last_tick = run_q && tick_i && (cnt_q == last);
  assign capture   = run_q && (kind_q == ACC_RD) && !ph_i && (cnt_q == CNT_W'(acc_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      div2_q <= 1'b0;
      cnt_q  <= '0;
      tim_q  <= '0;
      cyc_q  <= '0;
      acc_q  <= '0;
      kind_q <= ACC_CMD;
    end else if (accept_o) begin
      run_q  <= 1'b1;
      div2_q <= (div_i == 2'd2);
      cnt_q  <= '0;
      tim_q  <= onoff_i;
      cyc_q  <= cyc_i;
      acc_q  <= acc_i;
      kind_q <= acc_kind_e'(kind_i);
    end else if (last_tick) begin
      run_q <= 1'b0;
    end else if (run_q && tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      rv_q   <= 1'b0;
      rd_q   <= '0;
    end else begin
      done_q <= last_tick;
      rv_q   <= capture;
      if (capture) rd_q <= rd_data_i;
    end
  end

  assign run_o      = run_q;
  assign div2_o     = div2_q;
  assign cnt_o      = cnt_q;
  assign tim_o      = tim_q;
  assign cs_end_o   = cs_end;
  assign kind_o     = kind_q;
  assign done_o     = done_q;
  assign rd_data_o  = rd_q;
  assign rd_valid_o = rv_q;

  // R6: done follows the final busy clock
  a_r6_done_after_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (!run_q && $past(run_q)));
  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R8: illegal start leaves the block idle
  a_r8_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && start_i && !legal) |=> !run_q);
  // R9: latched settings hold for the whole access
  a_r9_hold_timing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !last_tick) |=> ($stable(tim_q) && $stable(kind_q) && $stable(cyc_q)));
  // R10: valid only on reads
  a_r10_valid_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rv_q |-> (kind_q == ACC_RD));
endmodule

// File: rtl/dst_pin_drv.sv
module dst_pin_drv #(
  parameter int N = 4
) (
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] pol_i,
  output logic [N-1:0] pin_o
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    assign pin_o[i] = pol_i[i] ? lvl_i[i] : ~lvl_i[i];
  end
endmodule

// File: rtl/disp_strobe_timer.sv
module disp_strobe_timer
  import disp_strobe_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        kind_i,
  input  logic [1:0]        clk_div_i,
  input  logic [29:0]       onoff_tim_i,
  input  logic [17:0]       cyc_tim_i,
  input  logic [5:0]        access_tick_i,
  input  logic [3:0]        pol_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              cs_o,
  output logic              we_o,
  output logic              re_o,
  output logic              a0_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  logic             accept, run, div2, tick, ph;
  logic [CNT_W-1:0] cnt, cs_end;
  onoff_t           tim;
  acc_kind_e        kind;

  dst_seq #(.DATA_W(DATA_W)) i_seq (
    .clk_i, .rst_ni, .start_i, .kind_i,
    .div_i     (clk_div_i),
    .onoff_i   (onoff_t'(onoff_tim_i)),
    .cyc_i     (cyc_t'(cyc_tim_i)),
    .acc_i     (access_tick_i),
    .rd_data_i,
    .tick_i    (tick),
    .ph_i      (ph),
    .accept_o  (accept),
    .run_o     (run),
    .div2_o    (div2),
    .cnt_o     (cnt),
    .tim_o     (tim),
    .cs_end_o  (cs_end),
    .kind_o    (kind),
    .done_o,
    .rd_data_o,
    .rd_valid_o
  );

  dst_tick_div i_div (
    .clk_i, .rst_ni,
    .clear_i (accept),
    .run_i   (run),
    .div2_i  (div2),
    .tick_o  (tick),
    .ph_o    (ph)
  );

  // window index: 0 cs, 1 we, 2 re
  logic [NSTB-1:0]            en, act;
  logic [NSTB-1:0][ON_W-1:0]  on_v;
  logic [NSTB-1:0][CNT_W-1:0] off_v;

  assign en[0]    = run;
  assign en[1]    = run && (kind != ACC_RD);
  assign en[2]    = run && (kind == ACC_RD);
  assign on_v[0]  = tim.cs_on;
  assign on_v[1]  = tim.we_on;
  assign on_v[2]  = tim.re_on;
  assign off_v[0] = cs_end;
  assign off_v[1] = CNT_W'(tim.we_off);
  assign off_v[2] = CNT_W'(tim.re_off);

  for (genvar s = 0; s < NSTB; s++) begin : g_win
    dst_window #(.CNT_W(CNT_W), .ON_W(ON_W), .OFF_W(OFF_W)) i_win (
      .en_i  (en[s]),
      .cnt_i (cnt),
      .on_i  (on_v[s]),
      .off_i (off_v[s]),
      .act_o (act[s])
    );
  end

  logic [3:0] lvl, pins;
  assign lvl = {act[0], act[1], act[2], kind != ACC_CMD};

  dst_pin_drv #(.N(4)) i_pins (
    .lvl_i (lvl),
    .pol_i (pol_i),
    .pin_o (pins)
  );

  assign {cs_o, we_o, re_o, a0_o} = pins;
  assign busy_o = run;

  // R1: idle means every strobe inactive
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (act == '0));
  // R3/R4: never both strobes in one access
  a_r3_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(act[1] && act[2]));
endmodule

// File: tb/test_disp_strobe_timer.sv
module test_disp_strobe_timer;
  localparam int DW = 16;

  logic          clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [1:0]    kind_i = 2'd0, clk_div_i = 2'd1;
  logic [29:0]   onoff_tim_i = '0;
  logic [17:0]   cyc_tim_i = '0;
  logic [5:0]    access_tick_i = '0;
  logic [3:0]    pol_i = 4'h0;
  logic [DW-1:0] rd_data_i = '0;
  logic          cs_o, we_o, re_o, a0_o, busy_o, done_o, rd_valid_o;
  logic [DW-1:0] rd_data_o;

  int checks = 0, failures = 0;

  always #2 clk_i = ~clk_i;

  disp_strobe_timer #(.DATA_W(DW)) i_disp_strobe_timer (.*);

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int pin(int lvl, int pol);
    return pol ? lvl : (lvl ? 0 : 1);
  endfunction

  function automatic logic [DW-1:0] dval(int k);
    return DW'(32'hA5C3 ^ (k * 37));
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // R12 packing
  function automatic logic [29:0] pack_oo(int cson, int csoff, int weon, int weoff, int reon, int reoff);
    return {6'(reoff), 4'(reon), 6'(weoff), 4'(weon), 6'(csoff), 4'(cson)};
  endfunction
  function automatic logic [17:0] pack_cy(int wecyc, int recyc, int gap);
    return {6'(gap), 6'(recyc), 6'(wecyc)};
  endfunction

  task automatic txn(int kind, int div, int cson, int csoff, int weon, int weoff,
                     int reon, int reoff, int wecyc, int recyc, int gap, int acc,
                     logic [3:0] pol, bit hold);
    int cse, n, nk, a0l;
    string rq;
    cse = imax(csoff, imax(weoff, reoff));
    n   = imax((kind == 2) ? recyc : wecyc, cse) + gap;
    nk  = n * div;
    a0l = (kind != 0);
    if (nk <= 4) hold = 0;
    rq  = (div == 2) ? "R6 R7" : "R6";
    @(negedge clk_i);
    kind_i = 2'(kind); clk_div_i = 2'(div); pol_i = pol;
    onoff_tim_i = pack_oo(cson, csoff, weon, weoff, reon, reoff);
    cyc_tim_i = pack_cy(wecyc, recyc, gap);
    access_tick_i = 6'(acc);
    start_i = 1'b1;
    for (int k = 0; k <= nk + 1; k++) begin
      int t;
      bit run;
      @(negedge clk_i);
      t = k / div;
      run = (k < nk);
      chk("R2 R11", "cs", cs_o, pin(run && t >= cson && t < cse, pol[3]));
      chk("R3 R11", "we", we_o, pin(run && kind != 2 && t >= weon && t < weoff, pol[2]));
      chk("R4 R11", "re", re_o, pin(run && kind == 2 && t >= reon && t < reoff, pol[1]));
      chk("R5 R11", "a0", a0_o, pin(a0l, pol[0]));
      chk(rq, "busy", busy_o, run);
      chk(hold ? "R9" : rq, "done", done_o, k == nk);
      chk("R10", "rd_valid", rd_valid_o, (kind == 2) && (k == acc * div + 1));
      if (kind == 2 && k == acc * div + 1)
        chk("R10", "rd_data", int'(rd_data_o), int'(dval(acc * div)));
      if (hold && k < 3) begin
        start_i = 1'b1;              // R9: must be ignored while busy
        kind_i  = 2'(k % 3);
        onoff_tim_i = ~onoff_tim_i;
        cyc_tim_i   = ~cyc_tim_i;
      end else start_i = 1'b0;
      rd_data_i = dval(k);
    end
  endtask

  task automatic rand_txn(bit hold);
    int kind, div, cson, csoff, weon, weoff, reon, reoff, wecyc, recyc, gap, acc;
    kind  = $urandom_range(2, 0);
    div   = $urandom_range(2, 1);
    cson  = $urandom_range(15, 0);
    csoff = $urandom_range(63, cson + 1);
    weon  = $urandom_range(15, 0);
    weoff = $urandom_range(40, weon + 1);
    reon  = $urandom_range(15, 0);
    reoff = $urandom_range(40, reon + 1);
    wecyc = $urandom_range(63, weoff);
    recyc = $urandom_range(63, reoff);
    gap   = $urandom_range(6, 0);
    acc   = $urandom_range(reoff, reon + 1);
    txn(kind, div, cson, csoff, weon, weoff, reon, reoff, wecyc, recyc, gap, acc,
        4'($urandom_range(15, 0)), hold);
  endtask

  task automatic reject(int div, int kind);
    @(negedge clk_i);
    clk_div_i = 2'(div); kind_i = 2'(kind); pol_i = 4'h0; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      chk("R8", "busy", busy_o, 0);
      chk("R8", "done", done_o, 0);
      chk("R8", "cs", cs_o, 1);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    // R1 reset state, active-low pins
    chk("R1", "busy", busy_o, 0);
    chk("R1", "done", done_o, 0);
    chk("R1", "rd_valid", rd_valid_o, 0);
    chk("R1", "cs", cs_o, 1);
    chk("R1", "we", we_o, 1);
    chk("R1", "re", re_o, 1);
    chk("R1", "a0", a0_o, 1);
    rst_ni = 1'b1;
    // R2: cs_off programmed below we_off is stretched
    txn(0, 1, 1, 3, 2, 7, 1, 2, 9, 4, 0, 1, 4'h0, 0);
    // R7 two-clock ticks, mixed polarity (R11)
    txn(1, 2, 0, 6, 1, 4, 0, 1, 6, 2, 3, 1, 4'b1010, 0);
    // R10 read with access tick late in the strobe
    txn(2, 1, 0, 9, 0, 1, 2, 8, 1, 10, 2, 7, 4'b0110, 0);
    // R9 start held high during a two-clock-tick read
    txn(2, 2, 1, 5, 0, 2, 3, 9, 3, 12, 1, 4, 4'hF, 1);
    // R8 illegal divider and kind
    reject(0, 1);
    reject(3, 0);
    reject(1, 3);
    for (int i = 0; i < 40; i++) rand_txn(i % 5 == 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule